// File: doc/BRIEF.md
# Set-Associative TLB with Staged Entry Loading

This block is a small translation lookaside buffer organised as a number of ways by a number of sets. A lookup presents a virtual page number (VPN). The low VPN bits pick a set and the remaining bits form the tag. Every way of that set compares its stored tag in the same cycle. The block reports one of three outcomes:

- a hit, which returns the physical page number (PPN) and the attribute bits;
- an invalid fault, where a tag matches but the entry's valid bit is clear;
- a miss, where nothing matches.

On an invalid fault the number of the faulting way is captured into a replacement-count register. On a miss that register steps round-robin instead.

Software fills an entry in three steps. It writes a staged high word (the VPN) and a staged low word (the PPN and attributes). It may overwrite the replacement count. It then issues a load command. The load copies both staged words into the way named by the replacement count, in the set selected by the staged VPN. The load commits at the clock edge, so a lookup in the same cycle still sees the old contents.

Top module: `tlb_lookup_loader`

## Requirements
- R1: After reset the replacement count is 0 and every entry has a zero tag and a zero low word. A lookup whose tag bits are all zero therefore reports an invalid fault in way 0, and any other lookup reports a miss.
- R2: The set index is lk_vpn[4:0] and the tag is lk_vpn[19:5]. A hit is reported in the same cycle as lk_req when an entry of that set has an equal tag and low-word bit 0 (valid) set. With the hit, lk_way, lk_ppn and lk_attr give the way, the PPN and the attributes. lk_ppn and lk_attr are zero whenever lk_hit is low.
- R3: When no valid entry matches but one or more invalid entries match the tag, lk_inval is raised and lk_way names the lowest-numbered matching way.
- R4: When lk_req is high, exactly one of lk_hit, lk_inval and lk_miss is high. lk_miss is raised when no entry of the set matches. When lk_req is low, all three flags are low.
- R5: An invalid fault loads the faulting way number into rc_q at the next clock edge.
- R6: A miss advances rc_q by one, modulo the way count, at the next clock edge.
- R7: rc_we writes rc_wdata into rc_q at the next edge, and it takes priority over any update caused by a lookup in the same cycle.
- R8: The staged low word is laid out as {PPN[19:0], key[1:0], size, cacheable, dirty, shared, valid}, with valid at bit 0. ld_cmd writes the staged VPN's tag and the staged low word into the entry of the way given by rc_q in that cycle, in the set given by the staged VPN.
- R9: A lookup issued in the same cycle as ld_cmd sees the contents from before the load.
- R10: stg_hi_we and stg_lo_we capture stg_hi_vpn and stg_lo_word at the clock edge. A load issued in the same cycle as a staged write uses the previously staged values.
- R11: When several valid entries match, the lowest-numbered way wins the hit.
- R12: rc_q holds its value in a cycle with no rc_we, no invalid fault and no miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | 20 | VPN to translate |
| lk_hit | output | 1 | Valid tag match |
| lk_inval | output | 1 | Tag match on an invalid entry only |
| lk_miss | output | 1 | No tag match |
| lk_way | output | 2 | Way of the hit or the invalid match, zero otherwise |
| lk_ppn | output | 20 | Translated PPN on a hit |
| lk_attr | output | 7 | Attribute bits on a hit |
| stg_hi_we | input | 1 | Write strobe for the staged high word |
| stg_hi_vpn | input | 20 | VPN for the staged high word |
| stg_lo_we | input | 1 | Write strobe for the staged low word |
| stg_lo_word | input | 27 | PPN and attributes for the staged low word |
| ld_cmd | input | 1 | Copy the staged pair into a TLB entry |
| rc_we | input | 1 | Software write to the replacement count |
| rc_wdata | input | 2 | Value for the replacement count |
| rc_q | output | 2 | Current replacement count |

## Verification
The bench builds the block with its default parameters: a 20-bit VPN and PPN, four ways and 32 sets. The random VPNs are drawn from only four tags across four sets. This makes the conditions of interest common rather than rare: duplicate tags across ways, invalid matches in a populated set, and wrap-around of the round-robin count. Directed steps cover the remaining orderings: a load colliding with a lookup, a load colliding with a staged write, and a software write to the count colliding with a miss.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // attribute field positions inside the low word (valid is bit 0)
  localparam int ATTR_W     = 7;
  localparam int A_VALID    = 0;
  localparam int A_SHARED   = 1;
  localparam int A_DIRTY    = 2;
  localparam int A_CACHE    = 3;
  localparam int A_SIZE     = 4;
  localparam int A_KEY_LO   = 5;

  typedef enum logic [1:0] {
    LK_IDLE  = 2'd0,
    LK_HIT   = 2'd1,
    LK_INVAL = 2'd2,
    LK_MISS  = 2'd3
  } lk_kind_e;
endpackage

// File: rtl/tlb_way_bank.sv
module tlb_way_bank #(
  parameter int SETS  = 32,
  parameter int SET_W = 5,
  parameter int TAG_W = 15,
  parameter int LO_W  = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_set,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [LO_W-1:0]  wr_lo,
  output logic             match_valid,
  output logic             match_inval,
  output logic [LO_W-1:0]  rd_lo
);
  import tlb_pkg::*;

  logic [TAG_W-1:0] tag_q [SETS];
  logic [LO_W-1:0]  lo_q  [SETS];
  logic             tag_eq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        tag_q[s] <= '0;
        lo_q[s]  <= '0;
      end
    end else if (wr_en) begin
      tag_q[wr_set] <= wr_tag;
      lo_q[wr_set]  <= wr_lo;
    end
  end

  always_comb begin
    rd_lo       = lo_q[rd_set];
    tag_eq      = (tag_q[rd_set] == rd_tag);
    match_valid = tag_eq &  rd_lo[A_VALID];
    match_inval = tag_eq & ~rd_lo[A_VALID];
  end
endmodule

// File: rtl/tlb_match_sel.sv
module tlb_match_sel #(
  parameter int WAYS = 4,
  parameter int RC_W = 2,
  parameter int LO_W = 27
) (
  input  logic [WAYS-1:0] vmatch,
  input  logic [WAYS-1:0] imatch,
  input  logic [LO_W-1:0] lo_by_way [WAYS],
  output logic            any_valid,
  output logic            any_inval,
  output logic [RC_W-1:0] sel_way,
  output logic [LO_W-1:0] sel_lo
);
  // lowest-numbered set bit, scanning from the top down
  function automatic logic [RC_W-1:0] lowest_way(input logic [WAYS-1:0] v);
    logic [RC_W-1:0] r;
    r = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (v[w]) r = RC_W'(w);
    end
    return r;
  endfunction

  logic [RC_W-1:0] vway, iway;

  always_comb begin
    any_valid = |vmatch;
    any_inval = |imatch;
    vway      = lowest_way(vmatch);
    iway      = lowest_way(imatch);
    sel_way   = any_valid ? vway : iway;
    sel_lo    = lo_by_way[sel_way];
  end
endmodule

// File: rtl/tlb_rc_ctrl.sv
module tlb_rc_ctrl #(
  parameter int RC_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_we,
  input  logic [RC_W-1:0] sw_val,
  input  logic            ev_inval,
  input  logic            ev_miss,
  input  logic [RC_W-1:0] ev_way,
  output logic [RC_W-1:0] rc_q
);
  // round-robin step; the way count is a power of two so the wrap is free
  function automatic logic [RC_W-1:0] rc_step(input logic [RC_W-1:0] v);
    return v + RC_W'(1);
  endfunction

  logic [RC_W-1:0] rc_d;

  always_comb begin
    rc_d = rc_q;
    if (sw_we)         rc_d = sw_val;
    else if (ev_inval) rc_d = ev_way;
    else if (ev_miss)  rc_d = rc_step(rc_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rc_q <= '0;
    else        rc_q <= rc_d;
  end
endmodule

// File: rtl/tlb_lookup_loader.sv
module tlb_lookup_loader #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20,
  parameter int SETS  = 32,
  parameter int WAYS  = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int TAG_W = VPN_W - SET_W,
  localparam int RC_W  = $clog2(WAYS),
  localparam int LO_W  = PPN_W + tlb_pkg::ATTR_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        lk_req,
  input  logic [VPN_W-1:0]            lk_vpn,
  output logic                        lk_hit,
  output logic                        lk_inval,
  output logic                        lk_miss,
  output logic [RC_W-1:0]             lk_way,
  output logic [PPN_W-1:0]            lk_ppn,
  output logic [tlb_pkg::ATTR_W-1:0]  lk_attr,
  input  logic                        stg_hi_we,
  input  logic [VPN_W-1:0]            stg_hi_vpn,
  input  logic                        stg_lo_we,
  input  logic [LO_W-1:0]             stg_lo_word,
  input  logic                        ld_cmd,
  input  logic                        rc_we,
  input  logic [RC_W-1:0]             rc_wdata,
  output logic [RC_W-1:0]             rc_q
);
  import tlb_pkg::*;

  function automatic logic [SET_W-1:0] set_of(input logic [VPN_W-1:0] v);
    return v[SET_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [VPN_W-1:0] v);
    return v[VPN_W-1:SET_W];
  endfunction

  // staged pair
  logic [VPN_W-1:0] stg_hi_q;
  logic [LO_W-1:0]  stg_lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_hi_q <= '0;
      stg_lo_q <= '0;
    end else begin
      if (stg_hi_we) stg_hi_q <= stg_hi_vpn;
      if (stg_lo_we) stg_lo_q <= stg_lo_word;
    end
  end

  // way banks
  logic [WAYS-1:0] vmatch, imatch;
  logic [LO_W-1:0] lo_by_way [WAYS];
  logic [WAYS-1:0] way_wr;

  genvar gw;
  generate
    for (gw = 0; gw < WAYS; gw++) begin : g_way
      assign way_wr[gw] = ld_cmd && (rc_q == RC_W'(gw));
      tlb_way_bank #(
        .SETS (SETS),
        .SET_W(SET_W),
        .TAG_W(TAG_W),
        .LO_W (LO_W)
      ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_set     (set_of(lk_vpn)),
        .rd_tag     (tag_of(lk_vpn)),
        .wr_en      (way_wr[gw]),
        .wr_set     (set_of(stg_hi_q)),
        .wr_tag     (tag_of(stg_hi_q)),
        .wr_lo      (stg_lo_q),
        .match_valid(vmatch[gw]),
        .match_inval(imatch[gw]),
        .rd_lo      (lo_by_way[gw])
      );
    end
  endgenerate

  // selection
  logic            any_valid, any_inval;
  logic [RC_W-1:0] sel_way;
  logic [LO_W-1:0] sel_lo;

  tlb_match_sel #(
    .WAYS(WAYS),
    .RC_W(RC_W),
    .LO_W(LO_W)
  ) u_sel (
    .vmatch   (vmatch),
    .imatch   (imatch),
    .lo_by_way(lo_by_way),
    .any_valid(any_valid),
    .any_inval(any_inval),
    .sel_way  (sel_way),
    .sel_lo   (sel_lo)
  );

  // lookup outcome as named events
  lk_kind_e lk_kind;
  logic     ev_hit, ev_inval, ev_miss;

  always_comb begin
    if (!lk_req)        lk_kind = LK_IDLE;
    else if (any_valid) lk_kind = LK_HIT;
    else if (any_inval) lk_kind = LK_INVAL;
    else                lk_kind = LK_MISS;
    ev_hit   = (lk_kind == LK_HIT);
    ev_inval = (lk_kind == LK_INVAL);
    ev_miss  = (lk_kind == LK_MISS);
  end

  assign lk_hit   = ev_hit;
  assign lk_inval = ev_inval;
  assign lk_miss  = ev_miss;
  assign lk_way   = (ev_hit || ev_inval) ? sel_way : '0;
  assign lk_ppn   = ev_hit ? sel_lo[LO_W-1:ATTR_W] : '0;
  assign lk_attr  = ev_hit ? sel_lo[ATTR_W-1:0] : '0;

  tlb_rc_ctrl #(
    .RC_W(RC_W)
  ) u_rc (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_we   (rc_we),
    .sw_val  (rc_wdata),
    .ev_inval(ev_inval),
    .ev_miss (ev_miss),
    .ev_way  (sel_way),
    .rc_q    (rc_q)
  );
endmodule

// File: rtl/tlb_lookup_checker.sv
module tlb_lookup_checker #(
  parameter int RC_W   = 2,
  parameter int PPN_W  = 20,
  parameter int ATTR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_req,
  input logic              lk_hit,
  input logic              lk_inval,
  input logic              lk_miss,
  input logic [RC_W-1:0]   lk_way,
  input logic [PPN_W-1:0]  lk_ppn,
  input logic [ATTR_W-1:0] lk_attr,
  input logic              rc_we,
  input logic [RC_W-1:0]   rc_wdata,
  input logic [RC_W-1:0]   rc_q
);
  p_one_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |-> ($countones({lk_hit, lk_inval, lk_miss}) == 1));

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |-> !(lk_hit || lk_inval || lk_miss));

  p_hit_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_attr[0]);

  p_nohit_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_ppn == '0 && lk_attr == '0));

  p_inval_way_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_inval && !rc_we) |=> (rc_q == $past(lk_way)));

  p_miss_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_miss && !rc_we) |=> (rc_q == RC_W'($past(rc_q) + 1'b1)));

  p_sw_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rc_we |=> (rc_q == $past(rc_wdata)));

  p_rc_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!rc_we && !lk_inval && !lk_miss) |=> $stable(rc_q));
endmodule

bind tlb_lookup_loader tlb_lookup_checker #(
  .RC_W  (RC_W),
  .PPN_W (PPN_W),
  .ATTR_W(tlb_pkg::ATTR_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .lk_req  (lk_req),
  .lk_hit  (lk_hit),
  .lk_inval(lk_inval),
  .lk_miss (lk_miss),
  .lk_way  (lk_way),
  .lk_ppn  (lk_ppn),
  .lk_attr (lk_attr),
  .rc_we   (rc_we),
  .rc_wdata(rc_wdata),
  .rc_q    (rc_q)
);

// File: tb/tb_tlb_lookup_loader.sv
module tb_tlb_lookup_loader;
  localparam int VW = 20, PW = 20, NS = 32, NW = 4, AW = 7, LW = PW + AW;
  localparam int SW = 5, TW = VW - SW, RW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          lk_req = 0, stg_hi_we = 0, stg_lo_we = 0, ld_cmd = 0, rc_we = 0;
  logic [VW-1:0] lk_vpn = '0, stg_hi_vpn = '0;
  logic [LW-1:0] stg_lo_word = '0;
  logic [RW-1:0] rc_wdata = '0;
  logic          lk_hit, lk_inval, lk_miss;
  logic [RW-1:0] lk_way, rc_q;
  logic [PW-1:0] lk_ppn;
  logic [AW-1:0] lk_attr;

  tlb_lookup_loader dut (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn),
    .lk_hit(lk_hit), .lk_inval(lk_inval), .lk_miss(lk_miss), .lk_way(lk_way),
    .lk_ppn(lk_ppn), .lk_attr(lk_attr), .stg_hi_we(stg_hi_we),
    .stg_hi_vpn(stg_hi_vpn), .stg_lo_we(stg_lo_we), .stg_lo_word(stg_lo_word),
    .ld_cmd(ld_cmd), .rc_we(rc_we), .rc_wdata(rc_wdata), .rc_q(rc_q)
  );

  // reference state
  logic [TW-1:0] m_tag [NW][NS];
  logic [LW-1:0] m_lo  [NW][NS];
  logic [VW-1:0] m_hi;
  logic [LW-1:0] m_stlo;
  logic [RW-1:0] m_rc;
  string         rc_tag = "R1";
  string         lk_tag_force = "";

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected lookup result: kind 0 idle, 1 hit, 2 inval, 3 miss
  function automatic int exp_kind(input logic [VW-1:0] v, output int way);
    int s = int'(v[SW-1:0]);
    way = 0;
    for (int w = 0; w < NW; w++)
      if (m_tag[w][s] == v[VW-1:SW] && m_lo[w][s][0]) begin way = w; return 1; end
    for (int w = 0; w < NW; w++)
      if (m_tag[w][s] == v[VW-1:SW]) begin way = w; return 2; end
    return 3;
  endfunction

  task automatic step(input bit req, input logic [VW-1:0] vpn,
                      input bit hwe, input logic [VW-1:0] hv,
                      input bit lwe, input logic [LW-1:0] lv,
                      input bit ld, input bit rwe, input logic [RW-1:0] rv);
    int k, w, s;
    string t;
    @(negedge clk);
    lk_req = req; lk_vpn = vpn; stg_hi_we = hwe; stg_hi_vpn = hv;
    stg_lo_we = lwe; stg_lo_word = lv; ld_cmd = ld; rc_we = rwe; rc_wdata = rv;
    #2;
    chk(rc_q == m_rc, rc_tag, "rc_q", rc_q, m_rc);
    k = req ? exp_kind(vpn, w) : 0;
    t = (k == 1) ? "R2" : (k == 2) ? "R3" : "R4";
    if (lk_tag_force != "") t = lk_tag_force;
    chk({lk_hit, lk_inval, lk_miss} == {k == 1, k == 2, k == 3}, t, "flags",
        {lk_hit, lk_inval, lk_miss}, {k == 1, k == 2, k == 3});
    if (k == 1 || k == 2) chk(lk_way == RW'(w), t, "way", lk_way, w);
    if (k == 1) begin
      s = int'(vpn[SW-1:0]);
      chk({lk_ppn, lk_attr} == m_lo[w][s], t, "ppn/attr", {lk_ppn, lk_attr}, m_lo[w][s]);
    end else begin
      chk({lk_ppn, lk_attr} == '0, "R2", "ppn/attr idle", {lk_ppn, lk_attr}, 0);
    end
    @(posedge clk);
    if (ld) begin
      m_tag[m_rc][m_hi[SW-1:0]] = m_hi[VW-1:SW];
      m_lo[m_rc][m_hi[SW-1:0]]  = m_stlo;
    end
    if (rwe)         begin m_rc = rv; rc_tag = "R7"; end
    else if (k == 2) begin m_rc = RW'(w); rc_tag = "R5"; end
    else if (k == 3) begin m_rc = m_rc + 1'b1; rc_tag = "R6"; end
    else             rc_tag = "R12";
    if (hwe) m_hi = hv;
    if (lwe) m_stlo = lv;
  endtask

  function automatic logic [VW-1:0] rvpn();
    return {TW'($urandom % 4), SW'($urandom % 4)};
  endfunction

  function automatic logic [LW-1:0] rlo();
    logic [LW-1:0] x = LW'($urandom);
    x[0] = ($urandom % 4) != 0;
    return x;
  endfunction

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int w = 0; w < NW; w++)
      for (int s = 0; s < NS; s++) begin m_tag[w][s] = '0; m_lo[w][s] = '0; end
    m_hi = '0; m_stlo = '0; m_rc = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state, zero tag gives invalid fault in way 0, other tag misses
    lk_tag_force = "R1";
    step(1, 20'h00003, 0, 0, 0, 0, 0, 0, 0);
    step(1, 20'h12345, 0, 0, 0, 0, 0, 0, 0);
    lk_tag_force = "";

    // R8: stage and load, then hit
    step(0, 0, 1, 20'h00041, 1, {20'hABCDE, 7'b1011011}, 0, 1, 2'd3);
    lk_tag_force = "R8";
    step(0, 0, 0, 0, 0, 0, 1, 0, 0);
    step(1, 20'h00041, 0, 0, 0, 0, 0, 0, 0);

    // R9: load colliding with lookup sees old contents
    step(0, 0, 1, 20'h00062, 1, {20'h11111, 7'h01}, 0, 0, 0);
    lk_tag_force = "R9";
    step(1, 20'h00062, 0, 0, 0, 0, 1, 0, 0);
    step(1, 20'h00062, 0, 0, 0, 0, 0, 0, 0);

    // R10: staged write in the load cycle, the load uses old staged pair
    lk_tag_force = "R10";
    step(0, 0, 1, 20'h000A7, 1, {20'h22222, 7'h01}, 1, 1, 2'd1);
    step(1, 20'h00062, 0, 0, 0, 0, 0, 0, 0);
    step(1, 20'h000A7, 0, 0, 0, 0, 0, 0, 0);

    // R11: same VPN valid in ways 0 and 2, lowest wins
    lk_tag_force = "R11";
    step(0, 0, 1, 20'h00105, 1, {20'h33333, 7'h03}, 0, 1, 2'd2);
    step(0, 0, 0, 0, 1, {20'h44444, 7'h05}, 1, 1, 2'd0);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0);
    step(1, 20'h00105, 0, 0, 0, 0, 0, 0, 0);

    // R7: software write beats a miss in the same cycle
    lk_tag_force = "";
    step(1, 20'hFFFFF, 0, 0, 0, 0, 0, 1, 2'd2);
    step(1, 20'hFFFFF, 0, 0, 0, 0, 0, 0, 0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 3) != 0, rvpn(),
           ($urandom % 3) == 0, rvpn(),
           ($urandom % 3) == 0, rlo(),
           ($urandom % 4) == 0,
           ($urandom % 8) == 0, RW'($urandom));
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule